// File: doc/BRIEF.md
# Serial Crosspoint Configuration Loader

This block is the serial programming path for the control state of an 8x8 crosspoint. A host sends one 32-bit word, one bit at a time. A bit is taken on each rising edge of the write strobe, but only while both chip enables are active. The word holds one 4-bit code for each of the eight outputs. The bits collect in a master register. A latch strobe then copies the master into the per-output slave state. In edge mode the copy happens on the latch rising edge. In level mode the slave follows the master while the latch is low.

Each code does one of the following to its output:
- routes the output to an input (0 to 7);
- routes the output to ground;
- enables the output, which also forces its routing to ground;
- disables the output, which leaves its routing as it was;
- nothing at all (reserved codes).

All strobes are sampled on the block clock, and edges are detected inside the block. A bit counter reports when a full word has been shifted since the last latch rising edge.

Top module: `crx_serial_loader`

## Requirements
- R1: A bit of `sdata_i` is shifted into the master only in a cycle where `wr_i` is sampled high after being low, `ce_i`=1 and `ce_ni`=0. Holding `wr_i` high shifts only one bit. A full load is 32 bits.
- R2: After 32 shifts, the first bit shifted is bit 3 of output 0's code, and the last bit is bit 0 of output 7's code. Output k's field is master bits [31-4k : 28-4k].
- R3: On transfer, codes 0000 to 0111 set the output's route to that input number. Code 1000 sets the route to ground, reported on `route_o` as value 8. `route_o` never exceeds 8.
- R4: On transfer, code 1001 sets the output's enable flag to 1 and forces its route to 8 (ground).
- R5: On transfer, code 1010 clears the output's enable flag and leaves its route unchanged.
- R6: Codes 1011 to 1111 leave that output's route and enable flag unchanged.
- R7: With `edge_mode_i`=1, the slave state changes only on a clock where `latch_i` is sampled high after being low. The new values are visible after that edge.
- R8: With `edge_mode_i`=0, the slave state is reloaded from the master on every clock where `latch_i` is low. It stays unchanged while `latch_i` is high.
- R9: `load_full_o` is 1 once 32 bits have been shifted since the last latch rising edge, and that edge clears it. A latch that comes before 32 bits still transfers the current master contents.
- R10: After reset, all enable flags are 0, all routes are 0, and `load_full_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sdata_i | input | 1 | Serial data bit |
| wr_i | input | 1 | Shift strobe, acts on its rising edge |
| ce_i | input | 1 | Active-high chip enable |
| ce_ni | input | 1 | Active-low chip enable |
| latch_i | input | 1 | Master-to-slave transfer strobe |
| edge_mode_i | input | 1 | 1: transfer on latch rising edge, 0: transparent while latch low |
| route_o | output | 32 | Route code per output, output k at bits [4k+3:4k], 8 = ground |
| en_o | output | 8 | Enable flag per output |
| load_full_o | output | 1 | 32 bits shifted since last latch rising edge |

## Verification
The first word enables all outputs. This separates the enable-forces-ground rule from plain routing. The next word is an ascending ramp of input numbers, which exposes any swap of field order or bit order within a field. A word that mixes disable, ground, reserved and routing codes shows that each field is decoded on its own, and that disable and reserved codes keep the old route. Further patterns check:
- chip-enable gating and a held write strobe;
- a 16-bit partial load, which yields a half-shifted master;
- a level-mode transfer, which separates the transparent behaviour from the edge behaviour.

// File: rtl/crx_pkg.sv
package crx_pkg;
  localparam int unsigned CODE_W = 4;
  localparam logic [CODE_W-1:0] CODE_GND = 4'b1000;
  localparam logic [CODE_W-1:0] CODE_EN  = 4'b1001;
  localparam logic [CODE_W-1:0] CODE_DIS = 4'b1010;

  typedef enum logic [1:0] {ACT_ROUTE, ACT_ENABLE, ACT_DISABLE, ACT_NONE} act_e;

  function automatic act_e decode_code(input logic [CODE_W-1:0] c);
    if (c <= CODE_GND)      return ACT_ROUTE;
    else if (c == CODE_EN)  return ACT_ENABLE;
    else if (c == CODE_DIS) return ACT_DISABLE;
    else                    return ACT_NONE;
  endfunction
endpackage

// File: rtl/crx_strobe_edge.sv
module crx_strobe_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic wr_i,
  input  logic latch_i,
  output logic wr_rise_o,
  output logic latch_rise_o
);
  logic wr_q, latch_q;

  // reset high so a strobe held high through reset is not an edge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q    <= 1'b1;
      latch_q <= 1'b1;
    end else begin
      wr_q    <= wr_i;
      latch_q <= latch_i;
    end
  end

  assign wr_rise_o    = wr_i & ~wr_q;
  assign latch_rise_o = latch_i & ~latch_q;
endmodule

// File: rtl/crx_master_shift.sv
module crx_master_shift #(
  parameter int unsigned WORD_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              shift_i,
  input  logic              sdata_i,
  input  logic              clr_cnt_i,
  output logic [WORD_W-1:0] master_o,
  output logic              full_o
);
  localparam int unsigned CNT_W = $clog2(WORD_W + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(WORD_W);

  logic [WORD_W-1:0] master_q;
  logic [CNT_W-1:0]  cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) master_q <= '0;
    else if (shift_i) master_q <= {master_q[WORD_W-2:0], sdata_i};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else if (clr_cnt_i) cnt_q <= shift_i ? CNT_W'(1) : '0;
    else if (shift_i && cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
  end

  assign master_o = master_q;
  assign full_o   = (cnt_q == CNT_MAX);
endmodule

// File: rtl/crx_slave_cell.sv
module crx_slave_cell
  import crx_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              xfer_i,
  input  logic [CODE_W-1:0] code_i,
  output logic [CODE_W-1:0] route_o,
  output logic              en_o
);
  act_e act;
  assign act = decode_code(code_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      route_o <= '0;
      en_o    <= 1'b0;
    end else if (xfer_i) begin
      case (act)
        ACT_ROUTE:   route_o <= code_i;
        ACT_ENABLE: begin
          en_o    <= 1'b1;
          route_o <= CODE_GND;  // enabling always grounds the output
        end
        ACT_DISABLE: en_o <= 1'b0;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/crx_serial_loader.sv
module crx_serial_loader
  import crx_pkg::*;
#(
  parameter int unsigned N_OUT = 8
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    sdata_i,
  input  logic                    wr_i,
  input  logic                    ce_i,
  input  logic                    ce_ni,
  input  logic                    latch_i,
  input  logic                    edge_mode_i,
  output logic [N_OUT*CODE_W-1:0] route_o,
  output logic [N_OUT-1:0]        en_o,
  output logic                    load_full_o
);
  localparam int unsigned WORD_W = N_OUT * CODE_W;

  logic              wr_rise, latch_rise, shift, xfer;
  logic [WORD_W-1:0] master;

  crx_strobe_edge u_edge (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .wr_i        (wr_i),
    .latch_i     (latch_i),
    .wr_rise_o   (wr_rise),
    .latch_rise_o(latch_rise)
  );

  assign shift = wr_rise & ce_i & ~ce_ni;
  assign xfer  = edge_mode_i ? latch_rise : ~latch_i;

  crx_master_shift #(.WORD_W(WORD_W)) u_master (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .shift_i  (shift),
    .sdata_i  (sdata_i),
    .clr_cnt_i(latch_rise),
    .master_o (master),
    .full_o   (load_full_o)
  );

  // first bit in lands at the MSB, so output 0 owns the top field
  for (genvar k = 0; k < N_OUT; k++) begin : g_out
    crx_slave_cell u_cell (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .xfer_i (xfer),
      .code_i (master[WORD_W-1-k*CODE_W -: CODE_W]),
      .route_o(route_o[k*CODE_W +: CODE_W]),
      .en_o   (en_o[k])
    );
  end
endmodule

// File: rtl/crx_serial_loader_chk.sv
module crx_serial_loader_chk #(
  parameter int unsigned N_OUT = 8
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               wr_i,
  input logic               ce_i,
  input logic               ce_ni,
  input logic               latch_i,
  input logic               edge_mode_i,
  input logic [N_OUT*4-1:0] route_o,
  input logic [N_OUT-1:0]   en_o,
  input logic               load_full_o
);
  AST_EDGE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (edge_mode_i && !(latch_i && !$past(latch_i))) |=> ($stable(route_o) && $stable(en_o))); // R7

  AST_LEVEL_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!edge_mode_i && latch_i) |=> ($stable(route_o) && $stable(en_o))); // R8

  AST_FULL_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (latch_i && !$past(latch_i)) |=> !load_full_o); // R9

  AST_NO_SHIFT_COUNT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!(ce_i && !ce_ni) && !(latch_i && !$past(latch_i))) |=> $stable(load_full_o)); // R1

  for (genvar k = 0; k < N_OUT; k++) begin : g_k
    AST_ROUTE_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      route_o[k*4 +: 4] <= 4'd8); // R3
    AST_ENABLE_GROUNDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(en_o[k]) |-> route_o[k*4 +: 4] == 4'd8); // R4
    AST_DISABLE_KEEPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(en_o[k]) |-> $stable(route_o[k*4 +: 4])); // R5
  end
endmodule

bind crx_serial_loader crx_serial_loader_chk #(.N_OUT(N_OUT)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .wr_i       (wr_i),
  .ce_i       (ce_i),
  .ce_ni      (ce_ni),
  .latch_i    (latch_i),
  .edge_mode_i(edge_mode_i),
  .route_o    (route_o),
  .en_o       (en_o),
  .load_full_o(load_full_o)
);

// File: tb/crx_serial_loader_test.sv
`timescale 1ns/1ps
module crx_serial_loader_test;
  logic clk = 0, rst_ni = 0;
  logic sdata = 0, wr = 0, ce = 1, ce_n = 0, latch = 1, edge_mode = 1;
  logic [31:0] route;
  logic [7:0]  en;
  logic        full;
  int checks = 0, errors = 0;

  logic [31:0] m_master = '0;
  int          m_cnt = 0;
  logic [3:0]  e_route [8];
  logic        e_en [8];

  always #2.5 clk = ~clk;

  crx_serial_loader uut (
    .clk_i(clk), .rst_ni(rst_ni), .sdata_i(sdata), .wr_i(wr), .ce_i(ce), .ce_ni(ce_n),
    .latch_i(latch), .edge_mode_i(edge_mode), .route_o(route), .en_o(en), .load_full_o(full)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_route();
    logic [31:0] r;
    for (int k = 0; k < 8; k++) r[k*4 +: 4] = e_route[k];
    return r;
  endfunction

  function automatic logic [7:0] exp_en();
    logic [7:0] r;
    for (int k = 0; k < 8; k++) r[k] = e_en[k];
    return r;
  endfunction

  // model of the slave update from the current master
  task automatic model_xfer();
    for (int k = 0; k < 8; k++) begin
      logic [3:0] c;
      c = m_master[31-4*k -: 4];
      if (c <= 4'd8) e_route[k] = c;
      else if (c == 4'd9) begin e_en[k] = 1'b1; e_route[k] = 4'd8; end
      else if (c == 4'd10) e_en[k] = 1'b0;
    end
  endtask

  task automatic check_all(input string req);
    chk(req, {32'd0, route}, {32'd0, exp_route()});
    chk(req, {56'd0, en}, {56'd0, exp_en()});
  endtask

  task automatic push_bit(input logic b, input int hold);
    @(negedge clk); sdata = b; wr = 1;
    for (int h = 0; h < hold; h++) @(negedge clk);
    wr = 0;
    if (ce && !ce_n) begin
      m_master = {m_master[30:0], b};
      if (m_cnt < 32) m_cnt++;
    end
  endtask

  task automatic shift_bits(input logic [31:0] w, input int n);
    for (int i = n - 1; i >= 0; i--) push_bit(w[i], 1);
    @(negedge clk);
  endtask

  task automatic latch_edge();
    @(negedge clk); latch = 0;
    @(negedge clk); latch = 1;
    model_xfer(); m_cnt = 0;
    @(negedge clk);
  endtask

  task automatic t_reset();
    for (int k = 0; k < 8; k++) begin e_route[k] = 0; e_en[k] = 0; end
    check_all("R10");
    chk("R10", {63'd0, full}, 64'd0);
  endtask

  task automatic t_enable_all();
    shift_bits(32'h9999_9999, 32);
    chk("R9 full", {63'd0, full}, 64'd1);
    check_all("R7 no change before latch");
    latch_edge();
    check_all("R4 enable grounds");
    chk("R9 cleared", {63'd0, full}, 64'd0);
  endtask

  task automatic t_ramp();
    shift_bits(32'h0123_4567, 32);
    check_all("R7 hold");
    latch_edge();
    check_all("R2 R3 ramp");
  endtask

  task automatic t_mixed();
    // out0 dis, out1 gnd, out2 reserved, out3 route 5, out4 dis, out5 reserved, out6 route 7, out7 route 0
    shift_bits(32'hA8F5_AC70, 32);
    latch_edge();
    check_all("R5 R6 mixed");
    chk("R6 out2 route kept", {60'd0, route[11:8]}, 64'd2);
    chk("R5 out0 route kept", {60'd0, route[3:0]}, 64'd0);
  endtask

  task automatic t_ce_gate();
    ce = 0; shift_bits(32'h1111_1111, 32); ce = 1;
    ce_n = 1; shift_bits(32'h2222_2222, 32); ce_n = 0;
    chk("R1 ce gate count", {63'd0, full}, 64'd0);
    for (int b = 0; b < 32; b++) push_bit(b[0], 4);  // held strobe: one shift each
    @(negedge clk);
    chk("R1 held wr", {63'd0, full}, 64'd1);
    latch_edge();
    check_all("R1 held wr");
  endtask

  task automatic t_partial();
    shift_bits(32'h0000_9B36, 16);
    chk("R9 partial not full", {63'd0, full}, 64'd0);
    latch_edge();
    check_all("R9 partial xfer");
  endtask

  task automatic t_level();
    shift_bits(32'h7654_3210, 32);
    edge_mode = 0;
    @(negedge clk);
    check_all("R8 held while high");
    latch = 0;
    @(negedge clk);
    model_xfer();
    check_all("R8 transparent");
    latch = 1; m_cnt = 0;
    @(negedge clk);
    shift_bits(32'h3333_3333, 32);
    check_all("R8 high blocks");
    edge_mode = 1;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_ni = 1;
    @(negedge clk);
    t_enable_all();
    t_ramp();
    t_mixed();
    t_ce_gate();
    t_partial();
    t_level();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #400000;
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule